// File: doc/BRIEF.md
# Third-Order Sinc Decimator for One-Bit Streams

This block turns the one-bit output of a sigma-delta modulator into 16-bit unsigned sample words. It runs on the modulator's bit clock and takes one data bit on every rising edge. Three wrapping integrators accumulate at the bit rate. Every N bits a decimation strobe passes the last integrator value through three differencing stages. The result is shifted down by an amount that depends on N and then clamped, so that any ratio gives the same 16-bit code scale: 0 for a stream with no ones, 32768 at half density, and 65535 for a stream of all ones.

The ratio N is chosen while the block runs, by a two-bit select, from 64, 128 and 256. The word rate is the bit clock divided by N. A change of select, like a reset, empties the filter, and the block holds back the first three decimated results so that no word from the settling transient is presented. Each word comes with a strobe that is high for one clock. The word is held until the next strobe.

Top module: `sinc3_decim`

## Requirements
- R1: `ratio_sel` sets N as 0 → 64, 1 → 128, 2 → 256 and 3 → 256. In steady operation `word_valid` rises once every N clocks.
- R2: A stream of all zeros gives the word 0 at every ratio.
- R3: A stream of all ones gives 65535 at every ratio. The scaled value 65536 saturates, and the raw differencing result never exceeds N cubed.
- R4: A stream with a ones density of 50% (8 ones in each 16 bits) gives 32768 ±1 at every ratio.
- R5: A ones density of 13/16 (81.25%) gives 53248 ±1, and 3/16 (18.75%) gives 12288 ±1, at every ratio.
- R6: `word_valid` is high for exactly one clock per word. `word_out` does not change while `word_valid` is low.
- R7: While `rst_n` is low (a synchronous reset), `word_out` is 0 and `word_valid` is 0. After release, the first three decimations are suppressed, and the first strobe is seen in the cycle after the 4·N-th rising edge that follows release.
- R8: A change of `ratio_sel` clears all filter state on the next rising edge. No strobe appears until the fourth decimation at the new ratio, which is seen after 4·N+1 rising edges counted from that edge. Its word is a settled value for the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator bit clock; one data bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Modulator data bit (0 or 1) |
| ratio_sel | input | 2 | Decimation ratio select: 0 = 64, 1 = 128, 2 or 3 = 256 |
| word_out | output | 16 | Unsigned filtered word, held between strobes |
| word_valid | output | 1 | One-clock strobe marking a new word |

## Verification
After reset is released, the bench counts rising edges and expects the first strobe exactly after edge 4·N. After a change of ratio it expects the first strobe after edge 4·N+1, because the clear itself takes one edge. Each following strobe is expected N edges after the previous one. Inputs change on the falling edge, and outputs are sampled on the falling edge that follows each counted rising edge, so a one-clock strobe is seen exactly once. The clock after each strobe is also sampled to confirm that the strobe has dropped and that the word has held.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
   typedef enum logic [1:0] {
      RSEL_LOW  = 2'd0,
      RSEL_MID  = 2'd1,
      RSEL_HIGH = 2'd2,
      RSEL_ALT  = 2'd3
   } rsel_e;

   // Folds the spare select code onto the highest ratio.
   function automatic logic [1:0] rsel_step(input rsel_e s);
      return (s == RSEL_ALT) ? 2'd2 : 2'(s);
   endfunction
endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
   parameter int ORDER = 3,
   parameter int ACC_W = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             bit_in,
   output logic [ACC_W-1:0] acc_out
);
   logic                        x_q;
   logic [ORDER-1:0][ACC_W-1:0] stg;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) x_q <= 1'b0;
      else               x_q <= bit_in;
   end

   for (genvar i = 0; i < ORDER; i++) begin : g_stage
      logic [ACC_W-1:0] acc;
      logic [ACC_W-1:0] addend;
      if (i == 0) begin : g_head
         assign addend = ACC_W'(x_q);
      end else begin : g_chain
         assign addend = stg[i-1];
      end
      always_ff @(posedge clk) begin
         if (!rst_n || clr) acc <= '0;
         else               acc <= acc + addend;
      end
      assign stg[i] = acc;
   end

   assign acc_out = stg[ORDER-1];
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
   parameter int ORDER = 3,
   parameter int ACC_W = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             dec_en,
   input  logic [ACC_W-1:0] sample,
   output logic [ACC_W-1:0] diff
);
   logic [ORDER:0][ACC_W-1:0] d;

   assign d[0] = sample;

   for (genvar i = 0; i < ORDER; i++) begin : g_stage
      logic [ACC_W-1:0] dly;
      always_ff @(posedge clk) begin
         if (!rst_n || clr) dly <= '0;
         else if (dec_en)   dly <= d[i];
      end
      assign d[i+1] = d[i] - dly;
   end

   assign diff = d[ORDER];
endmodule

// File: rtl/sinc3_scale.sv
module sinc3_scale #(
   parameter int ACC_W = 25,
   parameter int OUT_W = 16,
   parameter int SH_W  = 6
) (
   input  logic [ACC_W-1:0] val,
   input  logic [SH_W-1:0]  sh,
   output logic [OUT_W-1:0] code
);
   logic [ACC_W-1:0] shifted;

   assign shifted = val >> sh;

   always_comb begin
      if (|shifted[ACC_W-1:OUT_W]) code = '1;
      else                         code = shifted[OUT_W-1:0];
   end
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim #(
   parameter int ORDER     = 3,
   parameter int OUT_W     = 16,
   parameter int LOG_R_MIN = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_in,
   input  logic [1:0]       ratio_sel,
   output logic [OUT_W-1:0] word_out,
   output logic             word_valid
);
   import sinc3_pkg::*;

   localparam int LOG_R_MAX = LOG_R_MIN + 2;
   localparam int ACC_W     = ORDER * LOG_R_MAX + 1;
   localparam int CNT_W     = LOG_R_MAX;
   localparam int SH_W      = $clog2(ORDER * LOG_R_MAX + 1) + 1;
   localparam int SET_W     = $clog2(ORDER + 1);

   if (ORDER < 1) begin : g_bad_order
      $error("ORDER must be at least 1");
   end
   if (ORDER * LOG_R_MIN < OUT_W) begin : g_bad_scale
      $error("smallest ratio cannot fill the output word");
   end
   if (ACC_W <= OUT_W) begin : g_bad_width
      $error("accumulator must be wider than the output word");
   end

   logic [1:0]       ratio_q;
   logic             chg;
   logic [1:0]       step;
   logic [SH_W-1:0]  log_r;
   logic [SH_W-1:0]  sh;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last_cnt;
   logic             dec;
   logic [SET_W-1:0] settle_cnt;
   logic             settled;
   logic [ACC_W-1:0] integ_val;
   logic [ACC_W-1:0] comb_val;
   logic [OUT_W-1:0] code;

   // Ratio tracking: any change empties the filter on the next edge.
   always_ff @(posedge clk) ratio_q <= ratio_sel;
   assign chg      = (ratio_sel != ratio_q);
   assign step     = rsel_step(rsel_e'(ratio_q));
   assign log_r    = SH_W'(LOG_R_MIN) + SH_W'(step);
   assign sh       = SH_W'(ORDER) * log_r - SH_W'(OUT_W);
   assign last_cnt = {CNT_W{1'b1}} >> (SH_W'(LOG_R_MAX) - log_r);
   assign dec      = (cnt == last_cnt);
   assign settled  = (settle_cnt == SET_W'(ORDER));

   always_ff @(posedge clk) begin
      if (!rst_n || chg) cnt <= '0;
      else if (dec)      cnt <= '0;
      else               cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || chg)       settle_cnt <= '0;
      else if (dec && !settled) settle_cnt <= settle_cnt + 1'b1;
   end

   sinc3_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) i_integ (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (chg),
      .bit_in  (bit_in),
      .acc_out (integ_val)
   );

   sinc3_comb #(.ORDER(ORDER), .ACC_W(ACC_W)) i_comb (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (chg),
      .dec_en (dec),
      .sample (integ_val),
      .diff   (comb_val)
   );

   sinc3_scale #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SH_W(SH_W)) i_scale (
      .val  (comb_val),
      .sh   (sh),
      .code (code)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_out   <= '0;
         word_valid <= 1'b0;
      end else if (chg) begin
         word_valid <= 1'b0;
      end else begin
         word_valid <= dec && settled;
         if (dec && settled) word_out <= code;
      end
   end

   // Spacing tracker for the strobe-period check.
   logic [CNT_W:0] gap;
   logic           seen;
   always_ff @(posedge clk) begin
      if (!rst_n || chg) begin
         gap  <= '0;
         seen <= 1'b0;
      end else if (word_valid) begin
         gap  <= '0;
         seen <= 1'b1;
      end else begin
         gap  <= gap + 1'b1;
      end
   end

   p_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && seen) |-> (gap == {1'b0, last_cnt}));

   p_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (comb_val <= (ACC_W'(1) << (SH_W'(ORDER) * log_r))));

   p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !word_valid |-> $stable(word_out));

   p_reset_state_r7: assert property (@(posedge clk)
      $rose(rst_n) |-> (word_out == '0 && !word_valid));

   p_quiet_after_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> !word_valid);
endmodule

// File: tb/test_sinc3_decim.sv
`timescale 1ns/1ps
module test_sinc3_decim;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_in;
   logic [1:0]  ratio_sel = 2'd0;
   logic [15:0] word_out;
   logic        word_valid;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [3:0] ph = 4'd0;
   logic [4:0] ones16 = 5'd0;

   always #2.5 clk = ~clk;
   always @(negedge clk) ph <= ph + 4'd1;
   assign bit_in = ({1'b0, ph} < ones16);

   sinc3_decim i_sinc3_decim (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_in     (bit_in),
      .ratio_sel  (ratio_sel),
      .word_out   (word_out),
      .word_valid (word_valid)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic check_word(input string tag, input int exp);
      int a = int'(word_out);
      check((a - exp <= 1) && (exp - a <= 1), tag, a, exp);
   endtask

   function automatic int ratio_of(input logic [1:0] s);
      return (s == 2'd0) ? 64 : (s == 2'd1) ? 128 : 256;
   endfunction

   function automatic string tag_of(input logic [4:0] o);
      if (o == 5'd0)  return "R2 zeros";
      if (o == 5'd16) return "R3 ones";
      if (o == 5'd8)  return "R4 half";
      return "R5 density";
   endfunction

   task automatic wait_valid(output int n);
      n = 0;
      while (n < 3000) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (word_valid) break;
      end
   endtask

   task automatic do_reset(input logic [1:0] s, input logic [4:0] o);
      @(negedge clk);
      rst_n = 1'b0;
      ratio_sel = s;
      ones16 = o;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(word_out == 16'd0 && !word_valid, "R7 reset state", int'(word_out), 0);
      rst_n = 1'b1;
   endtask

   task automatic run_density(input logic [1:0] s, input logic [4:0] o);
      int n;
      int nr = ratio_of(s);
      int exp = (int'(o) * 4096 > 65535) ? 65535 : int'(o) * 4096;
      logic [15:0] held;
      do_reset(s, o);
      wait_valid(n);
      check(n == 4 * nr, "R7 first strobe edge", n, 4 * nr);
      check_word(tag_of(o), exp);
      held = word_out;
      @(posedge clk);
      @(negedge clk);
      check(!word_valid && word_out == held, "R6 strobe width and hold",
            int'(word_valid), 0);
      wait_valid(n);
      check(n == nr - 1, "R1 strobe period", n + 1, nr);
      check_word(tag_of(o), exp);
   endtask

   task automatic run_ratio_change();
      int n;
      do_reset(2'd0, 5'd13);
      wait_valid(n);
      check_word("R5 density before change", 53248);
      ratio_sel = 2'd2;
      wait_valid(n);
      check(n == 4 * 256 + 1, "R8 first strobe after change to 256", n, 4 * 256 + 1);
      check_word("R8 settled word at 256", 53248);
      ones16 = 5'd3;
      ratio_sel = 2'd1;
      wait_valid(n);
      check(n == 4 * 128 + 1, "R8 first strobe after change to 128", n, 4 * 128 + 1);
      check_word("R8 settled word at 128", 12288);
   endtask

   initial begin
      for (int s = 0; s < 4; s++) begin
         if (s == 3) begin
            run_density(2'd3, 5'd8);
         end else begin
            run_density(2'(s), 5'd0);
            run_density(2'(s), 5'd3);
            run_density(2'(s), 5'd8);
            run_density(2'(s), 5'd13);
            run_density(2'(s), 5'd16);
         end
      end
      run_ratio_change();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule